// File: doc/BRIEF.md
# Oldest-Operation Fallback Issue Selector

A load-store queue that compares addresses approximately can report conflicts that do not exist. If every pending operation sees such a false conflict, nothing issues and the queue stops making progress. This block makes sure that the single oldest pending memory operation can always issue. The operation may be a load or a store. It also merges that forced load into the regular load pick on the single load memory channel.

Each cycle the block looks for the oldest allocated, not-yet-issued load entry. The search is circular and starts at the one-hot load-queue head. The block then uses a per-entry "store is older" vector, which describes the store at the store-queue issue pointer, to decide which side holds the oldest operation.

- A fallback load is granted only when that load is the oldest, its address is known, and no store is awaiting its response.
- A fallback store lets a store through despite a reported conflict, but only when no load is the oldest and no issued load is still waiting for its data.

Allocation state, ordering, conflict results and memory response pointers all come in from the surrounding queue. All grants are registered and appear one clock after the inputs that caused them.

Top module: `fallback_issue_sel`

## Requirements
- R1: While `rst` is high at a clock edge, every output is zero after that edge.
- R2: The regular load pick is the first set bit of `ld_ready`, searched circularly from the `ldq_head_oh` position upward. If `ldq_head_oh` is zero, the search starts at entry 0. When no fallback load is granted, `ld_grant_oh` is that one-hot pick, `ld_grant_en` is the OR of `ld_ready`, and `ld_grant_src` is 1 when enabled and 0 otherwise. Each of these appears one cycle after its inputs.
- R3: The fallback candidate is the first entry with `ldq_alloc` set and `ldq_issued` clear, searched circularly from the head. Suppose three things hold for that entry: its `st_older_than_ld` bit is 0, its `ldq_addr_ok` bit is 1, and `stq_issue_ptr` equals `stq_resp_ptr`. Then the next cycle shows `ld_grant_oh` equal to the candidate, `ld_grant_en` equal to 1 and `ld_grant_src` equal to 2, overriding the regular pick.
- R4: No fallback load is granted while `stq_issue_ptr` differs from `stq_resp_ptr`.
- R5: No fallback load is granted when the candidate's `st_older_than_ld` bit is 1.
- R6: No fallback load is granted when the candidate's `ldq_addr_ok` bit is 0. The block does not pass over such a candidate to a younger entry. The regular pick is used instead.
- R7: `st_grant_en` is 1 one cycle after `st_req_valid` is 1 with `st_conflict` 0, and `st_grant_src` is then 1. It is 0 whenever `st_req_valid` was 0.
- R8: A store with `st_req_valid` 1 and `st_conflict` 1 is granted with `st_grant_src` equal to 2 only under two conditions. First, either no fallback candidate exists or the candidate's `st_older_than_ld` bit is 1. Second, no entry has `ldq_issued` set with `ldq_data_ok` clear.
- R9: Any entry with `ldq_issued` 1 and `ldq_data_ok` 0 blocks the fallback store in the following cycle.
- R10: Whenever `st_req_valid` is 1, `st_grant_idx` equals `stq_issue_ptr` one cycle later.
- R11: A fallback load and a fallback store are never granted in the same cycle. When conflicts are reported on every cycle, the oldest pending operation still issues whenever the conditions of R3 or R8 hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ldq_alloc | input | LDQ_DEPTH | Load entry is allocated |
| ldq_issued | input | LDQ_DEPTH | Load entry has been sent to memory |
| ldq_addr_ok | input | LDQ_DEPTH | Load entry address is valid |
| ldq_data_ok | input | LDQ_DEPTH | Load entry data has returned |
| ldq_head_oh | input | LDQ_DEPTH | One-hot load-queue head (oldest slot) |
| ld_ready | input | LDQ_DEPTH | Loads cleared by the regular conflict check |
| st_older_than_ld | input | LDQ_DEPTH | Store at issue pointer is older than load entry i |
| stq_issue_ptr | input | STQ_IW | Store-queue issue pointer |
| stq_resp_ptr | input | STQ_IW | Store-queue response pointer |
| st_req_valid | input | 1 | Store at issue pointer has address and data |
| st_conflict | input | 1 | Regular check reports a conflict for that store |
| ld_grant_oh | output | LDQ_DEPTH | One-hot load entry to issue |
| ld_grant_en | output | 1 | Load issue enable |
| ld_grant_src | output | 2 | 0 none, 1 regular, 2 fallback |
| st_grant_en | output | 1 | Store issue enable |
| st_grant_src | output | 2 | 0 none, 1 regular, 2 fallback |
| st_grant_idx | output | STQ_IW | Store entry being issued |

## Verification
The bench builds the block with a load queue of 6 entries and a store queue of 4 entries, with both fallback kinds turned on. A depth of 6 is not a power of two, so the circular search has to wrap through a modulo that is not a plain bit truncation. A head placed at entry 5 exercises that wrap. Together, the directed cases reach each blocking condition on its own: a pending store response, an older store, a missing address and an outstanding load. A closing sequence reports conflicts on every cycle and checks that two loads, a store and then a third load each issue within five cycles.

// File: rtl/fbs_pkg.sv
package fbs_pkg;

  typedef enum logic [1:0] {
    SRC_NONE     = 2'd0,
    SRC_REGULAR  = 2'd1,
    SRC_FALLBACK = 2'd2
  } issue_src_e;

endpackage

// File: rtl/fbs_cyc_pick.sv
module fbs_cyc_pick #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] req,
  input  logic [N-1:0] start_oh,
  output logic [N-1:0] grant_oh,
  output logic         any
);

  logic [IW-1:0] start_idx;

  always_comb begin
    start_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (start_oh[i]) start_idx = IW'(i);
    end
  end

  always_comb begin
    logic found;
    int   pos;
    grant_oh = '0;
    found    = 1'b0;
    for (int k = 0; k < N; k++) begin
      pos = (int'(start_idx) + k) % N;
      if (!found && req[pos]) begin
        grant_oh[pos] = 1'b1;
        found         = 1'b1;
      end
    end
  end

  assign any = |req;

endmodule

// File: rtl/fbs_age_judge.sv
module fbs_age_judge #(
  parameter int LDQ_DEPTH   = 4,
  parameter int STQ_IW      = 2,
  parameter bit FB_LOAD_EN  = 1'b1,
  parameter bit FB_STORE_EN = 1'b1
) (
  input  logic [LDQ_DEPTH-1:0] cand_oh,
  input  logic [LDQ_DEPTH-1:0] st_older,
  input  logic [LDQ_DEPTH-1:0] addr_ok,
  input  logic [LDQ_DEPTH-1:0] issued,
  input  logic [LDQ_DEPTH-1:0] data_ok,
  input  logic [STQ_IW-1:0]    st_iptr,
  input  logic [STQ_IW-1:0]    st_rptr,
  output logic [LDQ_DEPTH-1:0] fb_ld_oh,
  output logic                 fb_ld_en,
  output logic                 fb_st_ok
);

  logic [LDQ_DEPTH-1:0] load_first_oh;
  logic                 store_pending;
  logic                 load_pending;

  // non-zero only when the oldest un-issued load precedes the oldest store
  assign load_first_oh = cand_oh & ~st_older;
  assign store_pending = (st_iptr != st_rptr);
  assign load_pending  = |(issued & ~data_ok);

  generate
    if (FB_LOAD_EN) begin : g_fb_ld
      assign fb_ld_oh = load_first_oh & addr_ok & {LDQ_DEPTH{~store_pending}};
      assign fb_ld_en = |fb_ld_oh;
    end else begin : g_no_fb_ld
      assign fb_ld_oh = '0;
      assign fb_ld_en = 1'b0;
    end

    if (FB_STORE_EN) begin : g_fb_st
      assign fb_st_ok = ~(|load_first_oh) & ~load_pending;
    end else begin : g_no_fb_st
      assign fb_st_ok = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/fallback_issue_sel.sv
module fallback_issue_sel #(
  parameter int LDQ_DEPTH   = 4,
  parameter int STQ_DEPTH   = 4,
  parameter bit FB_LOAD_EN  = 1'b1,
  parameter bit FB_STORE_EN = 1'b1,
  localparam int STQ_IW = (STQ_DEPTH > 1) ? $clog2(STQ_DEPTH) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [LDQ_DEPTH-1:0] ldq_alloc,
  input  logic [LDQ_DEPTH-1:0] ldq_issued,
  input  logic [LDQ_DEPTH-1:0] ldq_addr_ok,
  input  logic [LDQ_DEPTH-1:0] ldq_data_ok,
  input  logic [LDQ_DEPTH-1:0] ldq_head_oh,
  input  logic [LDQ_DEPTH-1:0] ld_ready,
  input  logic [LDQ_DEPTH-1:0] st_older_than_ld,
  input  logic [STQ_IW-1:0]    stq_issue_ptr,
  input  logic [STQ_IW-1:0]    stq_resp_ptr,
  input  logic                 st_req_valid,
  input  logic                 st_conflict,
  output logic [LDQ_DEPTH-1:0] ld_grant_oh,
  output logic                 ld_grant_en,
  output logic [1:0]           ld_grant_src,
  output logic                 st_grant_en,
  output logic [1:0]           st_grant_src,
  output logic [STQ_IW-1:0]    st_grant_idx
);
  import fbs_pkg::*;

  logic [LDQ_DEPTH-1:0] reg_pick_oh, cand_oh, fb_ld_oh, waiting;
  logic                 reg_any, cand_any, fb_ld_en, fb_st_ok;
  logic [LDQ_DEPTH-1:0] ld_oh_d;
  logic                 ld_en_d, st_en_d;
  issue_src_e           ld_src_d, st_src_d;

  assign waiting = ldq_alloc & ~ldq_issued;

  fbs_cyc_pick #(.N(LDQ_DEPTH)) u_reg_pick (
    .req(ld_ready), .start_oh(ldq_head_oh), .grant_oh(reg_pick_oh), .any(reg_any)
  );

  fbs_cyc_pick #(.N(LDQ_DEPTH)) u_cand_pick (
    .req(waiting), .start_oh(ldq_head_oh), .grant_oh(cand_oh), .any(cand_any)
  );

  fbs_age_judge #(
    .LDQ_DEPTH(LDQ_DEPTH), .STQ_IW(STQ_IW),
    .FB_LOAD_EN(FB_LOAD_EN), .FB_STORE_EN(FB_STORE_EN)
  ) u_age (
    .cand_oh(cand_oh), .st_older(st_older_than_ld), .addr_ok(ldq_addr_ok),
    .issued(ldq_issued), .data_ok(ldq_data_ok),
    .st_iptr(stq_issue_ptr), .st_rptr(stq_resp_ptr),
    .fb_ld_oh(fb_ld_oh), .fb_ld_en(fb_ld_en), .fb_st_ok(fb_st_ok)
  );

  // load channel merge: fallback has priority over the regular pick
  always_comb begin
    ld_oh_d  = fb_ld_en ? fb_ld_oh : reg_pick_oh;
    ld_en_d  = fb_ld_en | reg_any;
    ld_src_d = fb_ld_en ? SRC_FALLBACK : (reg_any ? SRC_REGULAR : SRC_NONE);
  end

  // store channel: conflict may be overridden when the store is oldest
  always_comb begin
    st_en_d  = st_req_valid & (~st_conflict | fb_st_ok);
    st_src_d = SRC_NONE;
    if (st_en_d) st_src_d = st_conflict ? SRC_FALLBACK : SRC_REGULAR;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_grant_oh  <= '0;
      ld_grant_en  <= 1'b0;
      ld_grant_src <= 2'd0;
      st_grant_en  <= 1'b0;
      st_grant_src <= 2'd0;
      st_grant_idx <= '0;
    end else begin
      ld_grant_oh  <= ld_oh_d;
      ld_grant_en  <= ld_en_d;
      ld_grant_src <= ld_src_d;
      st_grant_en  <= st_en_d;
      st_grant_src <= st_src_d;
      st_grant_idx <= stq_issue_ptr;
    end
  end

  logic unused_cand_any;
  assign unused_cand_any = cand_any;

endmodule

// File: rtl/fallback_issue_sel_sva.sv
module fallback_issue_sel_sva #(
  parameter int LDQ_DEPTH = 4,
  parameter int STQ_DEPTH = 4,
  localparam int STQ_IW = (STQ_DEPTH > 1) ? $clog2(STQ_DEPTH) : 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic [LDQ_DEPTH-1:0] ldq_issued,
  input logic [LDQ_DEPTH-1:0] ldq_data_ok,
  input logic [STQ_IW-1:0]    stq_issue_ptr,
  input logic [STQ_IW-1:0]    stq_resp_ptr,
  input logic                 st_req_valid,
  input logic [LDQ_DEPTH-1:0] ld_grant_oh,
  input logic                 ld_grant_en,
  input logic [1:0]           ld_grant_src,
  input logic                 st_grant_en,
  input logic [1:0]           st_grant_src,
  input logic [STQ_IW-1:0]    st_grant_idx
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!ld_grant_en && !st_grant_en && ld_grant_oh == '0));

  assert_onehot_grant_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ld_grant_oh) && (ld_grant_en == (ld_grant_oh != '0)));

  assert_store_pending_blocks_R4: assert property (@(posedge clk) disable iff (rst)
    (stq_issue_ptr != stq_resp_ptr) |=> (ld_grant_src != 2'd2));

  assert_load_pending_blocks_R9: assert property (@(posedge clk) disable iff (rst)
    (|(ldq_issued & ~ldq_data_ok)) |=> (st_grant_src != 2'd2));

  assert_store_index_R10: assert property (@(posedge clk) disable iff (rst)
    st_req_valid |=> (st_grant_idx == $past(stq_issue_ptr)));

  assert_single_fallback_R11: assert property (@(posedge clk) disable iff (rst)
    !((ld_grant_src == 2'd2) && (st_grant_src == 2'd2)));

  assert_store_src_R7: assert property (@(posedge clk) disable iff (rst)
    (st_grant_en == (st_grant_src != 2'd0)));

endmodule

bind fallback_issue_sel fallback_issue_sel_sva #(
  .LDQ_DEPTH(LDQ_DEPTH), .STQ_DEPTH(STQ_DEPTH)
) u_sva (.*);

// File: tb/fallback_issue_sel_tb_top.sv
`timescale 1ns/1ps
module fallback_issue_sel_tb_top;
  localparam int NL = 6;
  localparam int NS = 4;
  localparam int SW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NL-1:0] alloc, issued, addr_ok, data_ok, head, ready, older;
  logic [SW-1:0] iptr, rptr;
  logic          sval, sconf;
  logic [NL-1:0] ld_oh;
  logic          ld_en, st_en;
  logic [1:0]    ld_src, st_src;
  logic [SW-1:0] st_idx;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  fallback_issue_sel #(.LDQ_DEPTH(NL), .STQ_DEPTH(NS)) dut_i (
    .clk(clk), .rst(rst), .ldq_alloc(alloc), .ldq_issued(issued),
    .ldq_addr_ok(addr_ok), .ldq_data_ok(data_ok), .ldq_head_oh(head),
    .ld_ready(ready), .st_older_than_ld(older), .stq_issue_ptr(iptr),
    .stq_resp_ptr(rptr), .st_req_valid(sval), .st_conflict(sconf),
    .ld_grant_oh(ld_oh), .ld_grant_en(ld_en), .ld_grant_src(ld_src),
    .st_grant_en(st_en), .st_grant_src(st_src), .st_grant_idx(st_idx)
  );

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic set_ld(logic [NL-1:0] a, logic [NL-1:0] i, logic [NL-1:0] ad,
                        logic [NL-1:0] d, logic [NL-1:0] h, logic [NL-1:0] r,
                        logic [NL-1:0] o);
    alloc = a; issued = i; addr_ok = ad; data_ok = d; head = h; ready = r; older = o;
  endtask

  task automatic set_st(logic [SW-1:0] ip, logic [SW-1:0] rp, logic v, logic c);
    iptr = ip; rptr = rp; sval = v; sconf = c;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ld_expect(string req, int oh, int en, int src);
    chk({req, " ld_oh"}, int'(ld_oh), oh);
    chk({req, " ld_en"}, int'(ld_en), en);
    chk({req, " ld_src"}, int'(ld_src), src);
  endtask

  task automatic t_reset();
    set_ld(6'h3f, 0, 6'h3f, 0, 6'b000001, 6'h3f, 0);
    set_st(2'd1, 2'd1, 1'b1, 1'b0);
    rst = 1'b1;
    step();
    ld_expect("R1", 0, 0, 0);
    chk("R1 st_en", int'(st_en), 0);
    chk("R1 st_idx", int'(st_idx), 0);
    rst = 1'b0;
  endtask

  task automatic t_regular();
    set_st(0, 0, 0, 0);
    set_ld(0, 0, 0, 0, 6'b000100, 6'b100010, 0);
    step(); ld_expect("R2 head2", 6'b100000, 1, 1);
    set_ld(0, 0, 0, 0, 6'b100000, 6'b000110, 0);
    step(); ld_expect("R2 wrap", 6'b000010, 1, 1);
    set_ld(0, 0, 0, 0, 6'b000001, 0, 0);
    step(); ld_expect("R2 idle", 0, 0, 0);
  endtask

  task automatic t_fb_load();
    set_st(2'd2, 2'd2, 0, 0);
    set_ld(6'b110110, 6'b000010, 6'b010000, 6'b000010, 6'b001000, 6'b000100, 0);
    step(); ld_expect("R3 fallback", 6'b010000, 1, 2);
    iptr = 2'd3;
    step(); ld_expect("R4 store pending", 6'b000100, 1, 1);
    iptr = 2'd2; older = 6'b010000;
    step(); ld_expect("R5 store older", 6'b000100, 1, 1);
    older = 0; addr_ok = 6'b100000;
    step(); ld_expect("R6 no addr", 6'b000100, 1, 1);
    ready = 0;
    step(); ld_expect("R6 no addr idle", 0, 0, 0);
  endtask

  task automatic t_store();
    set_ld(0, 0, 0, 0, 6'b000001, 0, 0);
    set_st(2'd3, 2'd3, 1, 0);
    step();
    chk("R7 st_en", int'(st_en), 1); chk("R7 st_src", int'(st_src), 1);
    chk("R10 st_idx", int'(st_idx), 3);
    sval = 0;
    step();
    chk("R7 invalid st_en", int'(st_en), 0);
    set_st(2'd1, 2'd1, 1, 1);
    step();
    chk("R8 fb st_en", int'(st_en), 1); chk("R8 fb st_src", int'(st_src), 2);
    chk("R10 st_idx", int'(st_idx), 1);
    set_ld(6'b000100, 0, 6'b000100, 0, 6'b000001, 0, 0);
    rptr = 2'd0;
    step();
    chk("R8 older load blocks", int'(st_en), 0);
    older = 6'b000100;
    step();
    chk("R8 store older", int'(st_src), 2);
    issued = 6'b001000;
    step();
    chk("R9 load pending", int'(st_en), 0);
    data_ok = 6'b001000;
    step();
    chk("R9 load returned", int'(st_src), 2);
  endtask

  task automatic t_progress();
    int issued_at = 0;
    set_ld(6'b000111, 0, 6'b000111, 0, 6'b000001, 0, 6'b000100);
    set_st(0, 0, 1, 1);
    step(); ld_expect("R11 load0", 6'b000001, 1, 2);
    chk("R11 st held", int'(st_en), 0);
    issued = 6'b000001; data_ok = 6'b000001;
    step(); ld_expect("R11 load1", 6'b000010, 1, 2);
    issued = 6'b000011; data_ok = 6'b000011;
    step(); ld_expect("R11 load2 waits", 0, 0, 0);
    chk("R11 store fb", int'(st_src), 2);
    set_st(1, 0, 0, 1); older = 0;
    step(); ld_expect("R11 resp pending", 0, 0, 0);
    rptr = 1;
    for (int c = 0; c < 3; c++) begin
      step();
      if (ld_src == 2'd2 && issued_at == 0) issued_at = c + 1;
    end
    chk("R11 load2 issued within bound", int'(issued_at != 0), 1);
    chk("R11 load2 oh", int'(ld_oh), 6'b000100);
  endtask

  initial begin
    set_ld(0, 0, 0, 0, 0, 0, 0);
    set_st(0, 0, 0, 0);
    @(negedge clk);
    t_reset();
    t_regular();
    t_fb_load();
    t_store();
    t_progress();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule